// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines, decides which of them should be forwarded to a processor, and supplies an 8-bit vector when the processor acknowledges. It holds three per-line state vectors: latched requests, a software mask, and the set of levels currently in service. A request is forwarded on `cpu_int` only when it is unmasked and outranks every level already in service. On acknowledge, the winning request moves into service. The controller can also clear the in-service bit at that moment without a command.

Software programs the block through a small synchronous write port: chip select, write strobe, one address bit and an 8-bit data word. An initialisation sequence always starts with the A0=0 word. It chooses edge or level sensing, a five-bit vector base and, optionally, automatic end of interrupt. After the sequence, A0=1 writes load the mask. A0=0 command words end service (specific or non-specific) and move the lowest-priority level. The lowest level can move automatically after each service or be set to a level named by software.

The vector leaves the block as a one-beat stream: `vec_valid` is high for exactly one cycle, the cycle after `cpu_ack` is sampled high. There is no ready input, so the processor side must take the beat when `vec_valid` is high. Back-pressure is not possible.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, and after any first initialisation word, the mask, the request latches and the in-service set are cleared. The lowest-priority level returns to 7. `cpu_int` stays low until the sequence completes. The first word is written with A0=0 and data bit 4 = 1, where bit 3 = level mode and bit 0 = fourth word follows. It is followed by the vector-base word (A0=1). If bit 0 was set, a fourth word (A0=1, bit 1 = automatic EOI) follows.
- R2: The vector-base word's bits 7:3 become vector bits 7:3. The vector's bits 2:0 are the number of the acknowledged line. `vec_valid` is high exactly in the cycle after `cpu_ack` is sampled high, and low otherwise.
- R3: With the default priority, line 0 is served first and line 7 last.
- R4: After initialisation, an A0=1 write loads the mask, where bit i = 1 blocks line i. A blocked request neither raises `cpu_int` nor is chosen. A latched request that is later unmasked is forwarded.
- R5: `cpu_int` is high only when some unmasked request has higher priority than every in-service level. An acknowledge honoured while `cpu_int` is high, without automatic EOI, adds the winner to the in-service set.
- R6: In edge mode, a request latches on a rising input. It stays latched after the input falls, and does not latch again until the input has been low. In level mode, the request follows the input, so a line that drops before acknowledge is withdrawn.
- R7: The command word with A0=0, bits 4:3 = 00 and bits 7:5 = 001 clears the highest-priority in-service bit.
- R8: Bits 7:5 = 011 clear the in-service bit named by data bits 2:0.
- R9: With automatic EOI selected, an acknowledge returns the vector but leaves the in-service set empty.
- R10: Bits 7:5 = 101 clear the highest-priority in-service bit and make that level lowest priority. Bits 7:5 = 100 enable, and 000 disable, making each level acknowledged under automatic EOI lowest priority.
- R11: Bits 7:5 = 110 make the level in bits 2:0 lowest priority. Bits 7:5 = 111 clear that level's in-service bit and make it lowest priority.
- R12: An acknowledge while `cpu_int` is low returns the base with low bits 111 and changes no request or in-service state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Chip select for the write port |
| bus_wr | input | 1 | Write strobe, sampled with bus_cs on the rising clock edge |
| bus_a0 | input | 1 | Address bit selecting the word type |
| bus_wdata | input | 8 | Write data |
| irq_in | input | 8 | Interrupt request lines, bit i is line i |
| cpu_int | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | Acknowledge from the processor, one cycle per acknowledge |
| vec_valid | output | 1 | Vector beat valid, one cycle |
| vec_data | output | 8 | Vector returned for the acknowledge |

## Verification
The bench builds the controller with its default parameters: eight lines and an 8-bit vector with a three-bit line field. With these values every lowest-level position and every wrap-around of the rotating order can be reached in a few writes. The bench programs a base of 0x40, so each returned vector shows the winning line directly in its low digit. With that, the priority order after rotation, specific rotation and spurious acknowledges can be read straight off the vector.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_IDX_W = $clog2(PIC_LINES);
  localparam int PIC_VEC_W = 8;

  typedef enum logic [1:0] {
    CFG_IDLE  = 2'd0,
    CFG_BASE  = 2'd1,
    CFG_EXTRA = 2'd2,
    CFG_RUN   = 2'd3
  } cfg_state_e;

  typedef enum logic [2:0] {
    OP_AROT_OFF = 3'b000,
    OP_NS_EOI   = 3'b001,
    OP_NOP      = 3'b010,
    OP_SP_EOI   = 3'b011,
    OP_AROT_ON  = 3'b100,
    OP_ROT_NS   = 3'b101,
    OP_SET_LOW  = 3'b110,
    OP_ROT_SP   = 3'b111
  } prio_op_e;

  typedef struct packed {
    logic                 valid;
    prio_op_e             op;
    logic [PIC_IDX_W-1:0] lvl;
  } prio_cmd_t;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int N_LINES = PIC_LINES,
  parameter int VEC_W   = PIC_VEC_W,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               wr,
  input  logic               a0,
  input  logic [7:0]         din,
  output logic [N_LINES-1:0] mask,
  output logic [BASE_W-1:0]  vec_base,
  output logic               level_mode,
  output logic               auto_eoi,
  output logic               rot_auto,
  output logic               ready,
  output logic               init_pulse,
  output prio_cmd_t          cmd
);
  cfg_state_e state;
  logic       want_extra;
  logic       wr_en;

  assign wr_en      = cs & wr;
  assign init_pulse = wr_en & ~a0 & din[4];
  assign ready      = (state == CFG_RUN);

  always_comb begin
    cmd.valid = wr_en & ~a0 & (din[4:3] == 2'b00) & ready;
    cmd.op    = prio_op_e'(din[7:5]);
    cmd.lvl   = din[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= CFG_IDLE;
      mask       <= '0;
      vec_base   <= '0;
      level_mode <= 1'b0;
      auto_eoi   <= 1'b0;
      rot_auto   <= 1'b0;
      want_extra <= 1'b0;
    end else if (init_pulse) begin
      state      <= CFG_BASE;
      level_mode <= din[3];
      want_extra <= din[0];
      mask       <= '0;
      auto_eoi   <= 1'b0;
      rot_auto   <= 1'b0;
    end else if (wr_en) begin
      case (state)
        CFG_BASE: if (a0) begin
          vec_base <= din[7:IDX_W];
          state    <= want_extra ? CFG_EXTRA : CFG_RUN;
        end
        CFG_EXTRA: if (a0) begin
          auto_eoi <= din[1];
          state    <= CFG_RUN;
        end
        CFG_RUN: begin
          if (a0) begin
            mask <= din[N_LINES-1:0];
          end else if (cmd.valid) begin
            if (cmd.op == OP_AROT_ON)  rot_auto <= 1'b1;
            if (cmd.op == OP_AROT_OFF) rot_auto <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pic_irr.sv
module pic_irr #(
  parameter int N_LINES = pic_pkg::PIC_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq,
  input  logic               level_mode,
  input  logic               flush,
  input  logic [N_LINES-1:0] take_clr,
  output logic [N_LINES-1:0] irr
);
  logic [N_LINES-1:0] irq_q;
  logic [N_LINES-1:0] rise;

  assign rise = irq & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
    end else begin
      irq_q <= irq;
      if (flush)           irr <= '0;
      else if (level_mode) irr <= irq & ~take_clr;
      else                 irr <= (irr | rise) & ~take_clr;
    end
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N_LINES = pic_pkg::PIC_LINES,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req,
  input  logic [IDX_W-1:0]   low,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    logic [IDX_W-1:0] pos;
    hit = 1'b0;
    idx = '0;
    pos = '0;
    for (int k = N_LINES; k >= 1; k--) begin
      pos = IDX_W'(int'(low) + k);
      if (req[pos]) begin
        hit = 1'b1;
        idx = pos;
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int N_LINES = PIC_LINES,
  parameter int VEC_W   = PIC_VEC_W,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs,
  input  logic               bus_wr,
  input  logic               bus_a0,
  input  logic [7:0]         bus_wdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic               cpu_int,
  input  logic               cpu_ack,
  output logic               vec_valid,
  output logic [VEC_W-1:0]   vec_data
);
  logic [N_LINES-1:0] mask, irr, isr, pending, take_clr, eoi_clr, isr_set;
  logic [BASE_W-1:0]  vec_base;
  logic               level_mode, auto_eoi, rot_auto, ready, init_pulse;
  prio_cmd_t          cmd;
  logic [IDX_W-1:0]   low, low_n, p_idx, s_idx, p_rank, s_rank;
  logic               p_hit, s_hit, take;

  pic_cfg #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cs(bus_cs), .wr(bus_wr), .a0(bus_a0),
    .din(bus_wdata), .mask(mask), .vec_base(vec_base),
    .level_mode(level_mode), .auto_eoi(auto_eoi), .rot_auto(rot_auto),
    .ready(ready), .init_pulse(init_pulse), .cmd(cmd)
  );

  pic_irr #(.N_LINES(N_LINES)) u_irr (
    .clk(clk), .rst_n(rst_n), .irq(irq_in), .level_mode(level_mode),
    .flush(init_pulse), .take_clr(take_clr), .irr(irr)
  );

  assign pending = irr & ~mask;

  pic_prio #(.N_LINES(N_LINES)) u_pend_res (
    .req(pending), .low(low), .hit(p_hit), .idx(p_idx)
  );

  pic_prio #(.N_LINES(N_LINES)) u_serv_res (
    .req(isr), .low(low), .hit(s_hit), .idx(s_idx)
  );

  // rank 0 is the level right after the lowest one
  assign p_rank  = p_idx - low - IDX_W'(1);
  assign s_rank  = s_idx - low - IDX_W'(1);
  assign cpu_int = ready & p_hit & (~s_hit | (p_rank < s_rank));
  assign take    = cpu_ack & cpu_int;

  assign take_clr = take ? (N_LINES'(1) << p_idx) : '0;
  assign isr_set  = (take && !auto_eoi) ? (N_LINES'(1) << p_idx) : '0;

  always_comb begin
    eoi_clr = '0;
    low_n   = low;
    if (cmd.valid) begin
      case (cmd.op)
        OP_NS_EOI: if (s_hit) eoi_clr = N_LINES'(1) << s_idx;
        OP_ROT_NS: if (s_hit) begin
          eoi_clr = N_LINES'(1) << s_idx;
          low_n   = s_idx;
        end
        OP_SP_EOI: eoi_clr = N_LINES'(1) << cmd.lvl;
        OP_ROT_SP: begin
          eoi_clr = N_LINES'(1) << cmd.lvl;
          low_n   = cmd.lvl;
        end
        OP_SET_LOW: low_n = cmd.lvl;
        default: ;
      endcase
    end
    if (take && auto_eoi && rot_auto) low_n = p_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr       <= '0;
      low       <= IDX_W'(N_LINES - 1);
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else if (init_pulse) begin
      isr       <= '0;
      low       <= IDX_W'(N_LINES - 1);
      vec_valid <= 1'b0;
    end else begin
      isr       <= (isr & ~eoi_clr) | isr_set;
      low       <= low_n;
      vec_valid <= cpu_ack;
      if (cpu_ack) vec_data <= take ? {vec_base, p_idx} : {vec_base, {IDX_W{1'b1}}};
    end
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int N_LINES = pic_pkg::PIC_LINES,
  parameter int VEC_W   = pic_pkg::PIC_VEC_W,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_cs,
  input logic               bus_wr,
  input logic               cpu_ack,
  input logic               cpu_int,
  input logic               vec_valid,
  input logic [VEC_W-1:0]   vec_data,
  input logic [BASE_W-1:0]  vec_base,
  input logic               ready,
  input logic               auto_eoi,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] irr,
  input logic [N_LINES-1:0] isr
);
  assert_quiet_until_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !cpu_int);

  assert_vec_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> vec_valid);

  assert_vec_only_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(cpu_ack));

  assert_vec_carries_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !(bus_cs && bus_wr)) |=> vec_data[VEC_W-1:IDX_W] == $past(vec_base));

  assert_int_needs_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((irr & ~mask) != '0));

  assert_take_enters_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_int && !auto_eoi && !(bus_cs && bus_wr))
      |=> $countones(isr) == $countones($past(isr)) + 1);

  assert_auto_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    auto_eoi |-> (isr == '0));
endmodule

bind pic_ctrl pic_ctrl_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_pic_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
  .cpu_ack(cpu_ack), .cpu_int(cpu_int), .vec_valid(vec_valid),
  .vec_data(vec_data), .vec_base(vec_base), .ready(ready),
  .auto_eoi(auto_eoi), .mask(mask), .irr(irr), .isr(isr)
);

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0, bus_wr = 1'b0, bus_a0 = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] irq_in = '0;
  logic       cpu_ack = 1'b0;
  logic       cpu_int, vec_valid;
  logic [7:0] vec_data;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pic_ctrl i_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
    .bus_a0(bus_a0), .bus_wdata(bus_wdata), .irq_in(irq_in),
    .cpu_int(cpu_int), .cpu_ack(cpu_ack), .vec_valid(vec_valid),
    .vec_data(vec_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic a0, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq_in = v;
    ticks(2);
  endtask

  task automatic ack_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    chk(req, {7'b0, vec_valid}, 8'h01);
    chk(req, vec_data, exp);
    @(negedge clk);
    chk("R2", {7'b0, vec_valid}, 8'h00);
  endtask

  task automatic init_pic(input logic ltim, input logic aeoi);
    irq_in = '0;
    ticks(2);
    put(1'b0, {4'b0001, ltim, 3'b001});
    put(1'b1, 8'h40);
    put(1'b1, {6'b0, aeoi, 1'b0});
  endtask

  task automatic t_reset();
    chk("R1", {7'b0, cpu_int}, 8'h00);
    chk("R1", {7'b0, vec_valid}, 8'h00);
    put(1'b0, 8'b0001_0001);
    irq_in = 8'h08;
    ticks(2);
    chk("R1", {7'b0, cpu_int}, 8'h00);
    put(1'b1, 8'h40);
    chk("R1", {7'b0, cpu_int}, 8'h00);
    put(1'b1, 8'h00);
    chk("R1", {7'b0, cpu_int}, 8'h01);
    ack_check("R2", 8'h43);
    put(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_fixed();
    init_pic(1'b0, 1'b0);
    set_irq(8'hA4);
    ack_check("R3", 8'h42);
    chk("R5", {7'b0, cpu_int}, 8'h00);
    put(1'b0, 8'h20);
    chk("R5", {7'b0, cpu_int}, 8'h01);
    ack_check("R3", 8'h45);
    put(1'b0, 8'h20);
    ack_check("R3", 8'h47);
    put(1'b0, 8'h20);
    chk("R3", {7'b0, cpu_int}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_nest();
    init_pic(1'b0, 1'b0);
    set_irq(8'h40);
    ack_check("R5", 8'h46);
    set_irq(8'h42);
    chk("R5", {7'b0, cpu_int}, 8'h01);
    ack_check("R5", 8'h41);
    put(1'b0, 8'h20);
    set_irq(8'h46);
    chk("R7", {7'b0, cpu_int}, 8'h01);
    ack_check("R7", 8'h42);
    put(1'b0, 8'h20);
    set_irq(8'hC6);
    chk("R5", {7'b0, cpu_int}, 8'h00);
    put(1'b0, 8'h66);
    chk("R8", {7'b0, cpu_int}, 8'h01);
    ack_check("R8", 8'h47);
    put(1'b0, 8'h67);
    chk("R8", {7'b0, cpu_int}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_mask();
    init_pic(1'b0, 1'b0);
    put(1'b1, 8'h08);
    set_irq(8'h08);
    chk("R4", {7'b0, cpu_int}, 8'h00);
    set_irq(8'h28);
    ack_check("R4", 8'h45);
    put(1'b0, 8'h20);
    chk("R4", {7'b0, cpu_int}, 8'h00);
    put(1'b1, 8'h00);
    chk("R4", {7'b0, cpu_int}, 8'h01);
    ack_check("R4", 8'h43);
    put(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_edge();
    init_pic(1'b0, 1'b0);
    set_irq(8'h10);
    set_irq(8'h00);
    chk("R6", {7'b0, cpu_int}, 8'h01);
    ack_check("R6", 8'h44);
    put(1'b0, 8'h20);
    chk("R6", {7'b0, cpu_int}, 8'h00);
    set_irq(8'h10);
    ack_check("R6", 8'h44);
    put(1'b0, 8'h20);
    ticks(2);
    chk("R6", {7'b0, cpu_int}, 8'h00);
    set_irq(8'h00);
  endtask

  task automatic t_level();
    init_pic(1'b1, 1'b0);
    set_irq(8'h04);
    chk("R6", {7'b0, cpu_int}, 8'h01);
    set_irq(8'h00);
    chk("R6", {7'b0, cpu_int}, 8'h00);
    set_irq(8'h04);
    ack_check("R6", 8'h42);
    chk("R6", {7'b0, cpu_int}, 8'h00);
    put(1'b0, 8'h20);
    chk("R6", {7'b0, cpu_int}, 8'h01);
    ack_check("R6", 8'h42);
    put(1'b0, 8'h20);
    set_irq(8'h00);
    chk("R6", {7'b0, cpu_int}, 8'h00);
  endtask

  task automatic t_aeoi();
    init_pic(1'b0, 1'b1);
    set_irq(8'h02);
    ack_check("R9", 8'h41);
    chk("R9", {7'b0, cpu_int}, 8'h00);
    set_irq(8'h42);
    chk("R9", {7'b0, cpu_int}, 8'h01);
    ack_check("R9", 8'h46);
    set_irq(8'h00);
  endtask

  task automatic t_autorot();
    init_pic(1'b0, 1'b0);
    set_irq(8'h01);
    ack_check("R10", 8'h40);
    put(1'b0, 8'hA0);
    set_irq(8'h00);
    set_irq(8'h03);
    ack_check("R10", 8'h41);
    put(1'b0, 8'hA0);
    ack_check("R10", 8'h40);
    put(1'b0, 8'h20);
    init_pic(1'b0, 1'b1);
    put(1'b0, 8'h80);
    set_irq(8'h03);
    ack_check("R10", 8'h40);
    ack_check("R10", 8'h41);
    set_irq(8'h00);
  endtask

  task automatic t_specrot();
    init_pic(1'b0, 1'b0);
    put(1'b0, 8'hC4);
    set_irq(8'h21);
    ack_check("R11", 8'h45);
    put(1'b0, 8'h20);
    ack_check("R11", 8'h40);
    put(1'b0, 8'h20);
    set_irq(8'h00);
    set_irq(8'h60);
    ack_check("R11", 8'h45);
    put(1'b0, 8'hE5);
    set_irq(8'h40);
    set_irq(8'h60);
    ack_check("R11", 8'h46);
    put(1'b0, 8'h20);
    ack_check("R11", 8'h45);
    put(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  task automatic t_spur();
    init_pic(1'b0, 1'b0);
    put(1'b1, 8'h08);
    set_irq(8'h08);
    chk("R12", {7'b0, cpu_int}, 8'h00);
    ack_check("R12", 8'h47);
    put(1'b1, 8'h00);
    chk("R12", {7'b0, cpu_int}, 8'h01);
    ack_check("R12", 8'h43);
    put(1'b0, 8'h20);
    set_irq(8'h00);
  endtask

  initial begin
    ticks(3);
    rst_n = 1'b1;
    ticks(1);
    t_reset();
    t_fixed();
    t_nest();
    t_mask();
    t_edge();
    t_level();
    t_aeoi();
    t_autorot();
    t_specrot();
    t_spur();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule